// File: doc/BRIEF.md
# Two-Level Branch Target Buffer Shared by Two Threads

This block predicts the target of taken branches for a front end that serves two hardware threads. It keeps two set-associative target stores. A small, fast first level answers a lookup one cycle after the lookup is accepted. A larger second level with five ways per set answers a fixed number of cycles after a first-level miss becomes known. Both threads compete for every entry. The thread id travels with a lookup and comes back with its response, but it takes no part in matching.

A lookup is offered with a valid signal and a fetch pointer. It is taken on a clock edge where the ready output is high. Exactly one response follows. The response carries a hit flag, the predicted target and the requesting thread id. When the first level hits, a new lookup may be taken in the same cycle as the response, so hits can stream at one per cycle. When the first level misses, the block probes the second level. While that probe is in progress the block keeps ready low, so only one probe is ever outstanding. A second-level hit copies the entry into the first level. A separate update port installs resolved taken branches into both levels at once.

Each level splits the pointer in its own way. The set index is the lowest log2(sets) bits of the pointer. The partial tag is the next tag-width bits. An entry stores a valid bit, the partial tag and the full target. Victims are chosen by a round-robin way pointer kept for each set.

Top module: `dual_level_btb`

## Requirements
- R1: After reset, rsp_valid is low and req_ready is high. Every entry of both levels is invalid, so the first lookup after reset misses both levels.
- R2: A lookup that hits the first level gives rsp_valid one cycle after it was accepted, with rsp_hit high and the stored target. In that response cycle req_ready stays high, so a second lookup can be accepted and answered on the following cycle.
- R3: A lookup that misses the first level is answered 1+L2_LAT cycles after acceptance, which is 4 with the default L2_LAT of 3. req_ready stays low from the acceptance until that response, so only one second-level probe is outstanding.
- R4: A second-level hit writes the entry into the first level. A repeat lookup of the same pointer then hits the first level with one-cycle latency.
- R5: A lookup that misses both levels still returns rsp_valid. Its rsp_hit is low and its rsp_target is zero.
- R6: When upd_valid is high, the pointer/target pair is written into both levels at that clock edge. If the pointer's partial tag is already present in its set, the matching way is overwritten in place, and neither the other ways nor the round-robin pointer change.
- R7: In each level, set index = ptr[log2(SETS)-1:0] and partial tag = the next TAG_W bits. A new tag goes into the way named by the set's round-robin pointer, which starts at way 0 and then advances. A fifth distinct tag in one first-level set (4 ways) evicts the first one installed, and that entry is still found in the second level.
- R8: The second-level pointer counts 0,1,2,3,4 and wraps to 0. A sixth distinct tag in one second-level set evicts the first one installed there.
- R9: Matching ignores the thread id. An entry installed while serving one thread hits for a lookup from the other thread, and rsp_tid returns the id of the lookup that was accepted.
- R10: If an update arrives in the same cycle as a second-level-hit response, the update is written and the promotion into the first level is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup offered |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_ptr | input | PTR_W | Fetch pointer to look up |
| req_tid | input | TID_W | Thread issuing the lookup |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | A target was found |
| rsp_target | output | PTR_W | Predicted target, zero on a miss |
| rsp_tid | output | TID_W | Thread of the answered lookup |
| upd_valid | input | 1 | Install a resolved taken branch |
| upd_ptr | input | PTR_W | Branch pointer to install |
| upd_target | input | PTR_W | Target to install |

## Verification
The bench shrinks the geometry to 4 first-level sets and 8 second-level sets, with 16-bit pointers, 8-bit partial tags and the default second-level latency of 3. The way counts stay at 4 and 5. With this geometry, a handful of pointers that differ only above bit 2 land in one set of each level. That brings first-level eviction, the second-level wrap from way 4 to way 0, promotion into a full set and in-place overwrite within reach in a few dozen cycles. Latency is checked from the edge of acceptance to the response, so any extra or missing register stage changes the counted value.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEEK = 2'd1,
      ST_DEEP = 2'd2
   } btb_phase_e;

   function automatic int unsigned way_bits(input int unsigned ways);
      return (ways > 1) ? $clog2(ways) : 1;
   endfunction

endpackage

// File: rtl/btb_rr_ptr.sv
module btb_rr_ptr #(
   parameter int unsigned SETS  = 128,
   parameter int unsigned WAYS  = 4,
   localparam int unsigned IDX_W = $clog2(SETS),
   localparam int unsigned WAY_W = btb_pkg::way_bits(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             adv,
   output logic [WAY_W-1:0] victim
);
   localparam bit POW2 = ((WAYS & (WAYS - 1)) == 0);

   logic [WAY_W-1:0] rr_q [SETS];
   logic [WAY_W-1:0] rr_nxt;

   assign victim = rr_q[idx];

   generate
      if (POW2) begin : g_wrap_natural
         assign rr_nxt = rr_q[idx] + 1'b1;
      end else begin : g_wrap_compare
         assign rr_nxt = (rr_q[idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx] + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else if (adv) begin
         rr_q[idx] <= rr_nxt;
      end
   end
endmodule

// File: rtl/btb_level.sv
module btb_level #(
   parameter int unsigned PTR_W = 32,
   parameter int unsigned SETS  = 128,
   parameter int unsigned WAYS  = 4,
   parameter int unsigned TAG_W = 12,
   localparam int unsigned IDX_W = $clog2(SETS),
   localparam int unsigned WAY_W = btb_pkg::way_bits(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] lk_ptr,
   output logic             lk_hit,
   output logic [PTR_W-1:0] lk_target,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [PTR_W-1:0] wr_target
);
   if (IDX_W + TAG_W > PTR_W) begin : g_bad_split
      $error("btb_level: index plus tag exceed pointer width");
   end
   if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_bad_sets
      $error("btb_level: SETS must be a power of two of at least 2");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("btb_level: WAYS must be at least 1");
   end

   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag;
   logic [WAYS-1:0]  lk_match, wr_match;
   logic [PTR_W-1:0] way_tgt [WAYS];
   logic [WAY_W-1:0] victim, wr_way;
   logic             unused_lk, unused_wr;

   assign lk_idx    = lk_ptr[IDX_W-1:0];
   assign lk_tag    = lk_ptr[IDX_W +: TAG_W];
   assign wr_idx    = wr_ptr[IDX_W-1:0];
   assign wr_tag    = wr_ptr[IDX_W +: TAG_W];
   assign unused_lk = ^lk_ptr;
   assign unused_wr = ^wr_ptr;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]  vld_q;
      logic [TAG_W-1:0] tag_q [SETS];
      logic [PTR_W-1:0] tgt_q [SETS];
      logic             sel;

      assign sel         = wr_en && (wr_way == WAY_W'(w));
      assign lk_match[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
      assign wr_match[w] = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
      assign way_tgt[w]  = tgt_q[lk_idx];

      always_ff @(posedge clk) begin
         if (!rst_n)   vld_q <= '0;
         else if (sel) vld_q[wr_idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
         end
      end
   end

   always_comb begin
      lk_target = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_match[w]) lk_target = lk_target | way_tgt[w];
      end
   end
   assign lk_hit = |lk_match;

   always_comb begin
      wr_way = victim;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (wr_match[w]) wr_way = WAY_W'(w);
      end
   end

   btb_rr_ptr #(.SETS(SETS), .WAYS(WAYS)) i_rr (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx    (wr_idx),
      .adv    (wr_en && !(|wr_match)),
      .victim (victim)
   );
endmodule

// File: rtl/btb_seq.sv
module btb_seq #(
   parameter int unsigned PTR_W  = 32,
   parameter int unsigned TID_W  = 1,
   parameter int unsigned L2_LAT = 3,
   localparam int unsigned CNT_W = $clog2(L2_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [PTR_W-1:0] req_ptr,
   input  logic [TID_W-1:0] req_tid,
   output logic             req_ready,
   output logic [PTR_W-1:0] look_ptr,
   input  logic             l1_hit,
   input  logic [PTR_W-1:0] l1_target,
   input  logic             l2_hit,
   input  logic [PTR_W-1:0] l2_target,
   input  logic             upd_valid,
   output logic             promo_en,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [PTR_W-1:0] rsp_target,
   output logic [TID_W-1:0] rsp_tid
);
   import btb_pkg::*;

   if (L2_LAT < 1) begin : g_bad_lat
      $error("btb_seq: L2_LAT must be at least 1");
   end

   btb_phase_e       ph_q;
   logic [PTR_W-1:0] ptr_q;
   logic [TID_W-1:0] tid_q;
   logic [CNT_W-1:0] cnt_q;
   logic             accept, deep_done;

   assign deep_done = (ph_q == ST_DEEP) && (cnt_q == CNT_W'(L2_LAT));
   assign req_ready = (ph_q == ST_IDLE) || ((ph_q == ST_PEEK) && l1_hit);
   assign accept    = req_valid && req_ready;
   assign look_ptr  = ptr_q;
   assign rsp_tid   = tid_q;

   always_comb begin
      rsp_valid  = 1'b0;
      rsp_hit    = 1'b0;
      rsp_target = '0;
      if ((ph_q == ST_PEEK) && l1_hit) begin
         rsp_valid  = 1'b1;
         rsp_hit    = 1'b1;
         rsp_target = l1_target;
      end else if (deep_done) begin
         rsp_valid  = 1'b1;
         rsp_hit    = l2_hit;
         rsp_target = l2_hit ? l2_target : '0;
      end
   end

   assign promo_en = deep_done && l2_hit && !upd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= ST_IDLE;
         cnt_q <= '0;
         ptr_q <= '0;
         tid_q <= '0;
      end else begin
         if (accept) begin
            ptr_q <= req_ptr;
            tid_q <= req_tid;
         end
         unique case (ph_q)
            ST_IDLE: if (accept) ph_q <= ST_PEEK;
            ST_PEEK: begin
               if (!l1_hit) begin
                  ph_q  <= ST_DEEP;
                  cnt_q <= CNT_W'(1);
               end else if (!accept) begin
                  ph_q <= ST_IDLE;
               end
            end
            ST_DEEP: begin
               if (deep_done) ph_q <= ST_IDLE;
               else           cnt_q <= cnt_q + 1'b1;
            end
            default: ph_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dual_level_btb.sv
module dual_level_btb #(
   parameter int unsigned PTR_W    = 32,
   parameter int unsigned TID_W    = 1,
   parameter int unsigned L1_SETS  = 128,
   parameter int unsigned L1_WAYS  = 4,
   parameter int unsigned L1_TAG_W = 12,
   parameter int unsigned L2_SETS  = 1024,
   parameter int unsigned L2_WAYS  = 5,
   parameter int unsigned L2_TAG_W = 12,
   parameter int unsigned L2_LAT   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [PTR_W-1:0] req_ptr,
   input  logic [TID_W-1:0] req_tid,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [PTR_W-1:0] rsp_target,
   output logic [TID_W-1:0] rsp_tid,
   input  logic             upd_valid,
   input  logic [PTR_W-1:0] upd_ptr,
   input  logic [PTR_W-1:0] upd_target
);
   if (L2_SETS * L2_WAYS < L1_SETS * L1_WAYS) begin : g_bad_levels
      $error("dual_level_btb: second level smaller than first level");
   end

   logic [PTR_W-1:0] look_ptr, l1_target, l2_target;
   logic             l1_hit, l2_hit, promo_en;
   logic             l1_wr_en;
   logic [PTR_W-1:0] l1_wr_ptr, l1_wr_tgt;

   assign l1_wr_en  = upd_valid || promo_en;
   assign l1_wr_ptr = upd_valid ? upd_ptr    : look_ptr;
   assign l1_wr_tgt = upd_valid ? upd_target : l2_target;

   btb_level #(.PTR_W(PTR_W), .SETS(L1_SETS), .WAYS(L1_WAYS), .TAG_W(L1_TAG_W)) i_l1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_ptr    (look_ptr),
      .lk_hit    (l1_hit),
      .lk_target (l1_target),
      .wr_en     (l1_wr_en),
      .wr_ptr    (l1_wr_ptr),
      .wr_target (l1_wr_tgt)
   );

   btb_level #(.PTR_W(PTR_W), .SETS(L2_SETS), .WAYS(L2_WAYS), .TAG_W(L2_TAG_W)) i_l2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_ptr    (look_ptr),
      .lk_hit    (l2_hit),
      .lk_target (l2_target),
      .wr_en     (upd_valid),
      .wr_ptr    (upd_ptr),
      .wr_target (upd_target)
   );

   btb_seq #(.PTR_W(PTR_W), .TID_W(TID_W), .L2_LAT(L2_LAT)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ptr    (req_ptr),
      .req_tid    (req_tid),
      .req_ready  (req_ready),
      .look_ptr   (look_ptr),
      .l1_hit     (l1_hit),
      .l1_target  (l1_target),
      .l2_hit     (l2_hit),
      .l2_target  (l2_target),
      .upd_valid  (upd_valid),
      .promo_en   (promo_en),
      .rsp_valid  (rsp_valid),
      .rsp_hit    (rsp_hit),
      .rsp_target (rsp_target),
      .rsp_tid    (rsp_tid)
   );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
   parameter int unsigned TID_W  = 1,
   parameter int unsigned L2_LAT = 3,
   localparam int unsigned AGE_W = $clog2(L2_LAT + 2) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [TID_W-1:0] req_tid,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic [TID_W-1:0] rsp_tid
);
   logic             pend_q;
   logic [AGE_W-1:0] age_q;
   logic [TID_W-1:0] tid_q;
   logic             take;

   assign take = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         age_q  <= '0;
         tid_q  <= '0;
      end else if (take) begin
         pend_q <= 1'b1;
         age_q  <= AGE_W'(1);
         tid_q  <= req_tid;
      end else if (rsp_valid) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         age_q <= age_q + 1'b1;
      end
   end

   // R2 R3: answers come only at the first-level or second-level latency
   assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> pend_q && (age_q == AGE_W'(1) || age_q == AGE_W'(L2_LAT + 1)));

   assert_deep_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && age_q == AGE_W'(L2_LAT + 1)) |-> rsp_valid);

   assert_single_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !rsp_valid) |-> !req_ready);

   assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |-> (req_ready && !rsp_valid));

   assert_hit_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   assert_tid_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_tid == tid_q));

   assert_hit_streams_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && age_q == AGE_W'(1)) |-> req_ready);
endmodule

bind dual_level_btb btb_checker #(.TID_W(TID_W), .L2_LAT(L2_LAT)) i_btb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_tid   (req_tid),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_tid   (rsp_tid)
);

// File: tb/test_dual_level_btb.sv
`timescale 1ns/1ps
module test_dual_level_btb;
   localparam int PW  = 16;
   localparam int LAT = 3;
   localparam int DEEP = 1 + LAT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [PW-1:0] req_ptr = '0;
   logic          req_tid = 1'b0;
   logic          rsp_valid, rsp_hit, rsp_tid;
   logic [PW-1:0] rsp_target;
   logic          upd_valid = 1'b0;
   logic [PW-1:0] upd_ptr = '0, upd_target = '0;

   int n_chk = 0, n_bad = 0, cyc = 0;

   always #2.5 clk = ~clk;

   dual_level_btb #(
      .PTR_W(PW), .TID_W(1), .L1_SETS(4), .L1_WAYS(4), .L1_TAG_W(8),
      .L2_SETS(8), .L2_WAYS(5), .L2_TAG_W(8), .L2_LAT(LAT)
   ) i_dual_level_btb (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ptr(req_ptr), .req_tid(req_tid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_target(rsp_target), .rsp_tid(rsp_tid), .upd_valid(upd_valid),
      .upd_ptr(upd_ptr), .upd_target(upd_target)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
         summary();
      end
   end

   task automatic install(input logic [PW-1:0] p, input logic [PW-1:0] t);
      @(negedge clk);
      upd_valid = 1'b1; upd_ptr = p; upd_target = t;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   // Offers one lookup; returns the response fields and cycles from acceptance.
   task automatic lookup(input logic [PW-1:0] p, input logic t, input bit upd_now,
                         input logic [PW-1:0] up, input logic [PW-1:0] ut,
                         output bit hit, output logic [PW-1:0] tgt, output int lat,
                         output bit leak, output logic tid_o);
      @(negedge clk);
      req_valid = 1'b1; req_ptr = p; req_tid = t;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1; leak = 1'b0;
      while (!rsp_valid && lat < 20) begin
         if (req_ready) leak = 1'b1;
         @(negedge clk);
         lat++;
      end
      hit = rsp_hit; tgt = rsp_target; tid_o = rsp_tid;
      if (upd_now) begin
         upd_valid = 1'b1; upd_ptr = up; upd_target = ut;
         @(negedge clk);
         upd_valid = 1'b0;
      end
   endtask

   task automatic expect_lookup(input logic [PW-1:0] p, input logic t, input string req,
                                input bit exp_hit, input logic [PW-1:0] exp_tgt,
                                input int exp_lat);
      bit h, lk; logic [PW-1:0] g; int l; logic ti;
      lookup(p, t, 1'b0, '0, '0, h, g, l, lk, ti);
      check(l == exp_lat, req, $sformatf("latency ptr 0x%0h", p), l, exp_lat);
      check(h == exp_hit, req, $sformatf("hit ptr 0x%0h", p), h, exp_hit);
      check(g == exp_tgt, req, $sformatf("target ptr 0x%0h", p), g, exp_tgt);
      check(ti == t, req, "rsp_tid", ti, t);
      if (l > 1) check(!lk, "R3", "req_ready low during probe", lk, 0);
   endtask

   task automatic t_reset_r1();
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
      check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
      expect_lookup(16'h0040, 1'b0, "R1/R5 cold miss", 1'b0, '0, DEEP);
   endtask

   task automatic t_fill_hit_r2_r9();
      install(16'h0008, 16'h1234);
      expect_lookup(16'h0008, 1'b0, "R2/R6", 1'b1, 16'h1234, 1);
      expect_lookup(16'h0008, 1'b1, "R9 other thread", 1'b1, 16'h1234, 1);
   endtask

   task automatic t_stream_r2();
      install(16'h0011, 16'hBEEF);
      @(negedge clk);
      req_valid = 1'b1; req_ptr = 16'h0008; req_tid = 1'b0;
      @(negedge clk);
      check(rsp_valid && rsp_hit, "R2", "first streamed hit", rsp_hit, 1);
      check(rsp_target == 16'h1234, "R2", "first streamed target", rsp_target, 16'h1234);
      check(req_ready == 1'b1, "R2", "ready in hit response", req_ready, 1);
      req_ptr = 16'h0011; req_tid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid && rsp_hit, "R2", "second streamed hit", rsp_hit, 1);
      check(rsp_target == 16'hBEEF, "R2", "second streamed target", rsp_target, 16'hBEEF);
      check(rsp_tid == 1'b1, "R9", "second streamed tid", rsp_tid, 1);
   endtask

   task automatic t_l1_evict_r7_r4();
      for (int k = 1; k <= 5; k++) install(PW'(k * 8 + 2), PW'(16'h2000 + k));
      expect_lookup(16'h000A, 1'b0, "R7 evicted from L1, found in L2", 1'b1, 16'h2001, DEEP);
      expect_lookup(16'h000A, 1'b1, "R4 promoted", 1'b1, 16'h2001, 1);
      expect_lookup(16'h0012, 1'b0, "R7 promotion victim", 1'b1, 16'h2002, DEEP);
      expect_lookup(16'h002A, 1'b0, "R7 recent entry stays", 1'b1, 16'h2005, 1);
   endtask

   task automatic t_l2_wrap_r8();
      for (int k = 1; k <= 6; k++) install(PW'(k * 8 + 4), PW'(16'h4000 + k));
      expect_lookup(16'h000C, 1'b0, "R8 wrapped out / R5", 1'b0, '0, DEEP);
      expect_lookup(16'h0014, 1'b0, "R8 second oldest kept", 1'b1, 16'h4002, DEEP);
   endtask

   task automatic t_overwrite_r6();
      for (int k = 1; k <= 4; k++) install(PW'(k * 8 + 6), PW'(16'h6000 + k));
      install(16'h000E, 16'h6AAA);
      expect_lookup(16'h000E, 1'b0, "R6 overwritten target", 1'b1, 16'h6AAA, 1);
      for (int k = 2; k <= 4; k++)
         expect_lookup(PW'(k * 8 + 6), 1'b0, "R6 neighbours kept", 1'b1, PW'(16'h6000 + k), 1);
   endtask

   task automatic t_promo_clash_r10();
      bit h, lk; logic [PW-1:0] g; int l; logic ti;
      for (int k = 1; k <= 5; k++) install(PW'(k * 8 + 5), PW'(16'h5000 + k));
      lookup(16'h000D, 1'b0, 1'b1, 16'h0007, 16'h7777, h, g, l, lk, ti);
      check(h && l == DEEP, "R10", "clash lookup deep hit", l, DEEP);
      expect_lookup(16'h000D, 1'b0, "R10 promotion dropped", 1'b1, 16'h5001, DEEP);
      expect_lookup(16'h0007, 1'b1, "R10 update written", 1'b1, 16'h7777, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_fill_hit_r2_r9();
      t_stream_r2();
      t_l1_evict_r7_r4();
      t_l2_wrap_r8();
      t_overwrite_r6();
      t_promo_clash_r10();
      repeat (2) @(negedge clk);
      summary();
   end
endmodule